// File: doc/BRIEF.md
# Interrupt Line Routing Crossbar

This block steers 128 level-sensitive interrupt request lines onto 24 lines that feed a downstream interrupt controller. Every request line has its own 32-bit steering word. The word holds an enable bit and the number of the output line that the request should drive. Any number of request lines may name the same output. That output then carries a shared request, which stays high while at least one of its enabled sources is high.

Software reaches the block through a plain word-addressed register port with an address, a write strobe, write data and read data. The steering words occupy word offsets 0 to 127, one per request line. Four read-only words at offsets 128 to 131 show the present level of every request line. The block does not latch, invert, mask or prioritise anything. Levels pass straight through, and the downstream controller decides how each line is triggered.

Top module: `irq_xbar_router`

## Requirements
- R1: A steering word with bit 31 set and bits [4:0] holding a value k from 0 to 23 makes `irq_out[k]` follow the level of its request line, and that request line drives no other output.
- R2: When several enabled request lines name the same output, that output is the OR of their levels.
- R3: A request line whose steering word has bit 31 clear, or whose bits [4:0] hold 24 or more, drives no output.
- R4: Bits [30:5] of a steering word read back exactly as written and have no effect on which output is driven.
- R5: Reset is synchronous and active high. It clears all 128 steering words to 0, so every steering word reads 0 and every output stays low whatever the request levels are.
- R6: A read at offset 128+w, for w from 0 to 3, returns the present levels of request lines 32w to 32w+31, with line n at bit n%32.
- R7: Status reads are not latched. A request pulse that ends before the read does not appear in the read result.
- R8: Writes to offsets 128 and above change nothing. Reads of offsets 132 to 255 return 0.
- R9: Each output follows its enabled sources combinationally. It falls as soon as all of them fall, with no latching or edge capture.
- R10: A steering write takes effect on the rising clock edge that accepts it. Before that edge the old route still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the steering registers |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 128 | Level-sensitive request lines, bit n is line n |
| irq_out | output | 24 | Combined lines toward the interrupt controller |
| bus_addr | input | 8 | Word offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |

## Verification
The checker watches several properties on every cycle. No output is high while all request lines are low. No more outputs are high than there are high request lines. A status-word read always equals the live request levels. An unmapped read is always zero. A steering write always reads back on the next cycle, and outputs are low just after reset. The bench scenarios cover the rest: which output a given steering word selects, OR-sharing between sources, and rejection of disabled or out-of-range selections. They also show that unused bits have no effect, that writes to status and unmapped offsets are dropped, that a short pulse leaves no trace, and on which edge a route change lands.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;

    localparam int unsigned XB_INPUTS     = 128;
    localparam int unsigned XB_OUTPUTS    = 24;
    localparam int unsigned XB_DATA_W     = 32;
    localparam int unsigned XB_SEL_W      = $clog2(XB_OUTPUTS);
    localparam int unsigned XB_STAT_WORDS = XB_INPUTS / XB_DATA_W;
    localparam int unsigned XB_ADDR_W     = $clog2(XB_INPUTS + XB_STAT_WORDS);
    localparam int unsigned XB_EN_BIT     = XB_DATA_W - 1;

    typedef struct packed {
        logic                en;
        logic [XB_SEL_W-1:0] sel;
    } route_t;

    typedef enum logic [1:0] {
        RGN_ROUTE  = 2'd0,
        RGN_STATUS = 2'd1,
        RGN_NONE   = 2'd2
    } region_t;

    function automatic route_t unpack_route(input logic [XB_DATA_W-1:0] word);
        route_t r;
        r.en  = word[XB_EN_BIT];
        r.sel = word[XB_SEL_W-1:0];
        return r;
    endfunction

    function automatic region_t classify(input logic [XB_ADDR_W-1:0] addr);
        if (int'(addr) < int'(XB_INPUTS))
            return RGN_ROUTE;
        else if (int'(addr) < int'(XB_INPUTS + XB_STAT_WORDS))
            return RGN_STATUS;
        else
            return RGN_NONE;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_IN = XB_INPUTS,
    parameter int unsigned DW     = XB_DATA_W,
    parameter int unsigned AW     = XB_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cfg_q [NUM_IN],
    output route_t        route [NUM_IN]
);

    localparam int unsigned IW = $clog2(NUM_IN);

    logic          hit;
    logic [IW-1:0] slot;

    assign hit  = wr_en && (classify(wr_addr) == RGN_ROUTE);
    assign slot = wr_addr[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NUM_IN); i++)
                cfg_q[i] <= '0;
        end else if (hit) begin
            cfg_q[slot] <= wr_data;
        end
    end

    for (genvar g = 0; g < int'(NUM_IN); g++) begin : g_decode
        assign route[g] = unpack_route(cfg_q[g]);
    end

endmodule

// File: rtl/irq_route_combine.sv
module irq_route_combine
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_IN  = XB_INPUTS,
    parameter int unsigned NUM_OUT = XB_OUTPUTS
) (
    input  route_t             route [NUM_IN],
    input  logic [NUM_IN-1:0]  irq_in,
    output logic [NUM_OUT-1:0] irq_out
);

    logic [NUM_OUT-1:0] dest [NUM_IN];

    for (genvar g = 0; g < int'(NUM_IN); g++) begin : g_dest
        always_comb begin
            dest[g] = '0;
            if (route[g].en && (int'(route[g].sel) < int'(NUM_OUT)))
                dest[g][route[g].sel] = 1'b1;
        end
    end

    always_comb begin
        irq_out = '0;
        for (int i = 0; i < int'(NUM_IN); i++)
            irq_out |= dest[i] & {NUM_OUT{irq_in[i]}};
    end

endmodule

// File: rtl/irq_bus_read.sv
module irq_bus_read
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_IN = XB_INPUTS,
    parameter int unsigned DW     = XB_DATA_W,
    parameter int unsigned AW     = XB_ADDR_W
) (
    input  logic [AW-1:0]     rd_addr,
    input  logic [DW-1:0]     cfg_q [NUM_IN],
    input  logic [NUM_IN-1:0] irq_in,
    output logic [DW-1:0]     rd_data
);

    localparam int unsigned IW  = $clog2(NUM_IN);
    localparam int unsigned SW  = NUM_IN / DW;
    localparam int unsigned SWW = (SW > 1) ? $clog2(SW) : 1;

    logic [DW-1:0]  stat_word [SW];
    logic [AW-1:0]  stat_off;

    for (genvar w = 0; w < int'(SW); w++) begin : g_stat
        assign stat_word[w] = irq_in[w*DW +: DW];
    end

    assign stat_off = rd_addr - AW'(NUM_IN);

    always_comb begin
        unique case (classify(rd_addr))
            RGN_ROUTE:  rd_data = cfg_q[rd_addr[IW-1:0]];
            RGN_STATUS: rd_data = stat_word[stat_off[SWW-1:0]];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_xbar_router.sv
module irq_xbar_router
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_IN  = XB_INPUTS,
    parameter int unsigned NUM_OUT = XB_OUTPUTS,
    parameter int unsigned DW      = XB_DATA_W,
    parameter int unsigned AW      = XB_ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  irq_in,
    output logic [NUM_OUT-1:0] irq_out,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata
);

    logic [DW-1:0] cfg_q [NUM_IN];
    route_t        route [NUM_IN];

    irq_route_regs #(.NUM_IN(NUM_IN), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .cfg_q   (cfg_q),
        .route   (route)
    );

    irq_route_combine #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_combine (
        .route   (route),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    irq_bus_read #(.NUM_IN(NUM_IN), .DW(DW), .AW(AW)) u_read (
        .rd_addr (bus_addr),
        .cfg_q   (cfg_q),
        .irq_in  (irq_in),
        .rd_data (bus_rdata)
    );

endmodule

// File: rtl/irq_xbar_checker.sv
module irq_xbar_checker
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_IN  = XB_INPUTS,
    parameter int unsigned NUM_OUT = XB_OUTPUTS,
    parameter int unsigned DW      = XB_DATA_W,
    parameter int unsigned AW      = XB_ADDR_W
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IN-1:0]  irq_in,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [AW-1:0]      bus_addr,
    input logic               bus_we,
    input logic [DW-1:0]      bus_wdata,
    input logic [DW-1:0]      bus_rdata
);

    localparam int unsigned SW = NUM_IN / DW;

    logic          rst_q;
    logic [DW-1:0] live_word;
    logic          in_status;
    logic          in_route;
    logic          unmapped;

    always_ff @(posedge clk) rst_q <= rst;

    assign in_route  = int'(bus_addr) < int'(NUM_IN);
    assign in_status = !in_route && (int'(bus_addr) < int'(NUM_IN + SW));
    assign unmapped  = !in_route && !in_status;

    always_comb live_word = DW'(irq_in >> (DW * (32'(bus_addr) - NUM_IN)));

    // R5: first cycle after reset has no route enabled
    always @(posedge clk) begin
        if (rst_q === 1'b1 && rst === 1'b0)
            a_r5_clear_after_reset: assert (irq_out == '0);
    end

    // R9: no request, no output
    a_r9_quiet_inputs: assert property (@(posedge clk) disable iff (rst)
        (irq_in == '0) |-> (irq_out == '0));

    // R1: one request line drives at most one output
    a_r1_fanout_bound: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out) <= $countones(irq_in));

    // R6: status word equals live input levels
    a_r6_status_live: assert property (@(posedge clk) disable iff (rst)
        in_status |-> (bus_rdata == live_word));

    // R8: unmapped offsets read zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (bus_rdata == '0));

    // R4: steering word reads back all bits on the next cycle
    a_r4_readback: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_we) && !$past(rst) && (int'($past(bus_addr)) < int'(NUM_IN))
         && (bus_addr == $past(bus_addr)) && !bus_we)
        |-> (bus_rdata == $past(bus_wdata)));

endmodule

bind irq_xbar_router irq_xbar_checker #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DW(DW), .AW(AW)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
);

// File: tb/test_irq_xbar_router.sv
module test_irq_xbar_router;

    localparam int NI = 128;
    localparam int NO = 24;

    typedef struct packed {
        logic [1:0]    kind;   // 0 write, 1 output check, 2 read check
        logic [3:0]    req;
        logic [7:0]    addr;
        logic [NI-1:0] data;
        logic [31:0]   expv;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] k, input logic [3:0] r,
                                input logic [7:0] a, input logic [NI-1:0] d,
                                input logic [31:0] e);
        vec_t v;
        v.kind = k; v.req = r; v.addr = a; v.data = d; v.expv = e;
        return v;
    endfunction

    localparam logic [NI-1:0] PAT = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [NI-1:0] ONES = '1;
    localparam int NV = 30;

    localparam vec_t VECS [NV] = '{
        mk(2'd1, 4'd5, 8'd0,   ONES, 32'h0),
        mk(2'd0, 4'd1, 8'd0,   128'h8000_0003, 32'h0),
        mk(2'd0, 4'd2, 8'd5,   128'h8000_0003, 32'h0),
        mk(2'd0, 4'd1, 8'd127, 128'h8000_0017, 32'h0),
        mk(2'd0, 4'd3, 8'd40,  128'h0000_0007, 32'h0),
        mk(2'd0, 4'd3, 8'd41,  128'h8000_0018, 32'h0),
        mk(2'd0, 4'd4, 8'd64,  128'h8ABC_0000, 32'h0),
        mk(2'd0, 4'd8, 8'd128, 128'hFFFF_FFFF, 32'h0),
        mk(2'd0, 4'd8, 8'd200, 128'h1234_5678, 32'h0),
        mk(2'd1, 4'd1, 8'd0,   128'h1, 32'h0000_0008),
        mk(2'd1, 4'd2, 8'd0,   128'h20, 32'h0000_0008),
        mk(2'd1, 4'd2, 8'd0,   128'h21, 32'h0000_0008),
        mk(2'd1, 4'd1, 8'd0,   128'h8000_0000_0000_0000_0000_0000_0000_0000, 32'h0080_0000),
        mk(2'd1, 4'd3, 8'd0,   128'h300_0000_0000, 32'h0),
        mk(2'd1, 4'd4, 8'd0,   128'h1_0000_0000_0000_0000, 32'h0000_0001),
        mk(2'd1, 4'd9, 8'd0,   128'h0, 32'h0),
        mk(2'd1, 4'd2, 8'd0,   128'h8000_0000_0000_0001_0000_0000_0000_0001, 32'h0080_0009),
        mk(2'd1, 4'd3, 8'd0,   ONES, 32'h0080_0009),
        mk(2'd2, 4'd4, 8'd64,  128'h0, 32'h8ABC_0000),
        mk(2'd2, 4'd4, 8'd41,  128'h0, 32'h8000_0018),
        mk(2'd2, 4'd3, 8'd40,  128'h0, 32'h0000_0007),
        mk(2'd2, 4'd6, 8'd128, PAT, 32'h7654_3210),
        mk(2'd2, 4'd6, 8'd129, PAT, 32'hFEDC_BA98),
        mk(2'd2, 4'd6, 8'd130, PAT, 32'h89AB_CDEF),
        mk(2'd2, 4'd6, 8'd131, PAT, 32'h0123_4567),
        mk(2'd2, 4'd8, 8'd128, 128'h0, 32'h0),
        mk(2'd2, 4'd8, 8'd200, PAT, 32'h0),
        mk(2'd2, 4'd8, 8'd132, PAT, 32'h0),
        mk(2'd2, 4'd8, 8'd255, ONES, 32'h0),
        mk(2'd1, 4'd9, 8'd0,   128'h4, 32'h0)
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [NI-1:0] irq_in;
    logic [NO-1:0] irq_out;
    logic [7:0]    bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_xbar_router i_irq_xbar_router (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic string tag(input int id);
        case (id)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input int id, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag(id), act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_out(input int id, input logic [NI-1:0] in, input logic [31:0] exp);
        @(negedge clk);
        irq_in = in;
        #5;
        check(id, 32'(irq_out), exp);
    endtask

    task automatic check_rd(input int id, input logic [7:0] a, input logic [NI-1:0] in,
                            input logic [31:0] exp);
        @(negedge clk);
        irq_in = in; bus_addr = a;
        #5;
        check(id, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                2'd0: do_write(VECS[i].addr, VECS[i].data[31:0]);
                2'd1: check_out(int'(VECS[i].req), VECS[i].data, VECS[i].expv);
                default: check_rd(int'(VECS[i].req), VECS[i].addr, VECS[i].data, VECS[i].expv);
            endcase
        end

        // R10: new route for line 0 lands on the accepting edge
        @(negedge clk);
        irq_in = 128'h1;
        bus_addr = 8'd0; bus_wdata = 32'h8000_0001; bus_we = 1'b1;
        #5;
        check(10, 32'(irq_out), 32'h0000_0008);
        @(posedge clk);
        #3;
        check(10, 32'(irq_out), 32'h0000_0002);
        @(negedge clk);
        bus_we = 1'b0;

        // R7: live level visible, finished pulse not recorded
        check_rd(7, 8'd128, 128'h8, 32'h0000_0008);
        @(negedge clk);
        irq_in = 128'h8;
        @(negedge clk);
        irq_in = '0;
        check_rd(7, 8'd128, 128'h0, 32'h0);

        // R5: reset again clears every steering word
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_rd(5, 8'd64, ONES, 32'h0);
        check_rd(5, 8'd0, ONES, 32'h0);
        check_out(5, ONES, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule